// File: doc/BRIEF.md
# Write Command Frame Receiver

This block sits behind a gap-interval decoder in a contactless tag and turns its stream of decoded bits into a memory programming request. Each frame must open with a fixed two-bit write opcode, sent as 1 then 0. The lock flag follows, then a 32-bit data word, then a 3-bit block address. Data and address arrive most significant bit first. That makes 38 bits in a valid frame.

The decoder signals each bit with a strobe and its value. It flags a malformed interval with an error strobe and marks the end of a frame with an end strobe. A frame is committed only when the end strobe finds exactly 38 bits, the opcode correct and no error. The block then issues a one-cycle write request, with the lock flag, data and address held on its outputs.

Every other outcome abandons the frame and raises a one-cycle return-to-read indication. The block then ignores the decoder until the next end strobe, and the bit after that end strobe starts a new frame.

Top module: `wr_frame_rx`

## Requirements
- R1: After reset, `wrReq`, `rdReturn`, `wrLock`, `wrData` and `wrAddr` are all zero.
- R2: A frame of exactly 38 bits is committed. It consists of opcode bits 1 then 0, the lock bit, 32 data bits MSB first and 3 address bits MSB first. On the cycle after the end strobe, `wrReq` is high and `wrLock`, `wrData`, `wrAddr` carry the received fields.
- R3: `wrReq` is high for one cycle only, and `wrLock`, `wrData` and `wrAddr` change only on a commit.
- R4: If an opcode bit differs from the expected value, `rdReturn` pulses on the cycle after that bit, and that frame produces no `wrReq`.
- R5: An end strobe that finds a bit count other than 38, including zero, gives a `rdReturn` pulse and no `wrReq`.
- R6: A 39th bit arriving before the end strobe is an overrun. `rdReturn` pulses on the cycle after it, and there is no `wrReq`.
- R7: An error strobe during a frame gives a `rdReturn` pulse on the next cycle and no `wrReq`. This holds even when the error strobe and the end strobe fall in the same cycle after 38 good bits.
- R8: After an abort, bits and errors are ignored and cause no pulse or output change until the next end strobe. That end strobe itself gives no pulse, and the following bit starts a fresh frame.
- R9: When a bit strobe and the end strobe fall in the same cycle, the bit is counted first and belongs to the ending frame.
- R10: `wrReq` and `rdReturn` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitValid | input | 1 | One-cycle strobe: a decoded bit is present |
| bitValue | input | 1 | Value of the decoded bit |
| decodeErr | input | 1 | One-cycle strobe: interval decoding failed |
| frameEnd | input | 1 | One-cycle strobe: end of the frame |
| wrReq | output | 1 | One-cycle programming request |
| wrData | output | 32 | Data word of the last committed frame |
| wrAddr | output | 3 | Block address of the last committed frame |
| wrLock | output | 1 | Lock flag of the last committed frame |
| rdReturn | output | 1 | One-cycle indication that the frame was abandoned |

## Verification
Two pairs of events can land on the same clock edge, and the bench drives each pair together on one negative edge. First, the 38th bit and the end strobe arrive in one cycle. The scoreboard must then see a write request that carries that final address bit. Second, the error strobe and the end strobe arrive in one cycle after a full, correct frame. The scoreboard must then see only a return-to-read pulse, and the outputs must still hold the previous committed fields.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
  typedef enum logic {ST_LISTEN, ST_DISCARD} rxState_e;

  typedef struct packed {
    logic shiftEn;
    logic commitEn;
  } dpCtrl_t;
endpackage

// File: rtl/wfr_ctrl.sv
module wfr_ctrl
  import wfr_pkg::*;
#(
  parameter int OPC_W = 2,
  parameter logic [OPC_W-1:0] OPCODE = 2'b10,
  parameter int FRAME_LEN = 38
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitValid,
  input  logic    bitValue,
  input  logic    decodeErr,
  input  logic    frameEnd,
  output dpCtrl_t dpCtrl,
  output logic    wrReq,
  output logic    rdReturn
);
  localparam int CNT_W = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_LEN);

  rxState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext, effCnt;
  logic expBit, inOpc, overrun, opcBad, listening;
  logic abortNow, commitNow;

  // expected opcode bit for the current position, first bit is the MSB
  always_comb begin
    expBit = 1'b0;
    for (int i = 0; i < OPC_W; i++) begin
      if (cnt == CNT_W'(i)) expBit = OPCODE[OPC_W-1-i];
    end
  end

  assign listening = (state == ST_LISTEN);
  assign inOpc     = (cnt < CNT_W'(OPC_W));
  assign overrun   = bitValid && (cnt == FRAME_CNT);
  assign opcBad    = bitValid && inOpc && (bitValue != expBit);
  assign effCnt    = cnt + CNT_W'(bitValid);

  assign commitNow = listening && frameEnd && !decodeErr && !overrun && !opcBad
                     && (effCnt == FRAME_CNT);
  assign abortNow  = listening && (decodeErr || overrun || opcBad
                     || (frameEnd && (effCnt != FRAME_CNT)));

  always_comb begin
    dpCtrl.shiftEn  = listening && bitValid && !decodeErr && !overrun && !opcBad;
    dpCtrl.commitEn = commitNow;
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    if (listening) begin
      if (frameEnd) begin
        cntNext = '0;
      end else if (abortNow) begin
        stateNext = ST_DISCARD;
        cntNext   = '0;
      end else if (bitValid) begin
        cntNext = cnt + 1'b1;
      end
    end else if (frameEnd) begin
      stateNext = ST_LISTEN;
      cntNext   = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_LISTEN;
      cnt      <= '0;
      wrReq    <= 1'b0;
      rdReturn <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      wrReq    <= commitNow;
      rdReturn <= abortNow;
    end
  end

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !wrReq);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrReq && rdReturn));
  p_err_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (listening && decodeErr) |=> (rdReturn && !wrReq));
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rstN)
    (listening && bitValid && cnt == FRAME_CNT) |=> rdReturn);
  p_opcode_r4: assert property (@(posedge clk) disable iff (!rstN)
    (listening && bitValid && cnt == '0 && bitValue != OPCODE[OPC_W-1]) |=> rdReturn);
  p_short_r5: assert property (@(posedge clk) disable iff (!rstN)
    (listening && frameEnd && !bitValid && cnt != FRAME_CNT) |=> (rdReturn && !wrReq));
  p_discard_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DISCARD) |=> (!wrReq && !rdReturn));
endmodule

// File: rtl/wfr_datapath.sv
module wfr_datapath
  import wfr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValue,
  input  dpCtrl_t           dpCtrl,
  output logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrLock
);
  localparam int SR_W = 1 + DATA_W + ADDR_W;

  logic [SR_W-1:0] shiftReg, shiftNext, srEff;

  assign shiftNext = {shiftReg[SR_W-2:0], bitValue};
  // a bit that arrives with the end strobe is part of the committed word
  assign srEff     = dpCtrl.shiftEn ? shiftNext : shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (dpCtrl.shiftEn) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLock <= 1'b0;
      wrData <= '0;
      wrAddr <= '0;
    end else if (dpCtrl.commitEn) begin
      wrLock <= srEff[SR_W-1];
      wrData <= srEff[SR_W-2:ADDR_W];
      wrAddr <= srEff[ADDR_W-1:0];
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.commitEn |=> ($stable(wrData) && $stable(wrAddr) && $stable(wrLock)));
endmodule

// File: rtl/wr_frame_rx.sv
module wr_frame_rx
  import wfr_pkg::*;
#(
  parameter int OPC_W = 2,
  parameter logic [OPC_W-1:0] OPCODE = 2'b10,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitValue,
  input  logic              decodeErr,
  input  logic              frameEnd,
  output logic              wrReq,
  output logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrLock,
  output logic              rdReturn
);
  localparam int FRAME_LEN = OPC_W + 1 + DATA_W + ADDR_W;

  dpCtrl_t dpCtrl;

  wfr_ctrl #(
    .OPC_W(OPC_W), .OPCODE(OPCODE), .FRAME_LEN(FRAME_LEN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitValue(bitValue),
    .decodeErr(decodeErr), .frameEnd(frameEnd), .dpCtrl(dpCtrl),
    .wrReq(wrReq), .rdReturn(rdReturn)
  );

  wfr_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .bitValue(bitValue), .dpCtrl(dpCtrl),
    .wrData(wrData), .wrAddr(wrAddr), .wrLock(wrLock)
  );

  p_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!wrReq && !rdReturn));
endmodule

// File: tb/test_wr_frame_rx.sv
module test_wr_frame_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0, bitValue = 1'b0, decodeErr = 1'b0, frameEnd = 1'b0;
  logic wrReq, wrLock, rdReturn;
  logic [31:0] wrData;
  logic [2:0] wrAddr;

  int checks = 0;
  int errors = 0;

  // expected events: kind 1 = write request, 0 = abort; word = {lock,data,addr}
  bit          expKind[$];
  logic [35:0] expWord[$];
  string       expTag[$];

  always #10 clk = ~clk;

  wr_frame_rx i_wr_frame_rx (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitValue(bitValue),
    .decodeErr(decodeErr), .frameEnd(frameEnd), .wrReq(wrReq),
    .wrData(wrData), .wrAddr(wrAddr), .wrLock(wrLock), .rdReturn(rdReturn)
  );

  function automatic logic [38:0] mkFrame(input logic [1:0] opc, input logic lock,
                                          input logic [31:0] data, input logic [2:0] addr);
    return {1'b0, opc, lock, data, addr};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expectReq(input logic lock, input logic [31:0] data,
                           input logic [2:0] addr, input string tag);
    expKind.push_back(1'b1); expWord.push_back({lock, data, addr}); expTag.push_back(tag);
  endtask

  task automatic expectAbort(input string tag);
    expKind.push_back(1'b0); expWord.push_back('0); expTag.push_back(tag);
  endtask

  // sends bits[n-1] down to bits[0]; optionally the end strobe rides on the last bit
  task automatic sendBits(input logic [38:0] bits, input int n, input bit endWithLast);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      bitValid = 1'b1;
      bitValue = bits[i];
      frameEnd = endWithLast && (i == 0);
    end
    @(negedge clk);
    bitValid = 1'b0; bitValue = 1'b0; frameEnd = 1'b0;
  endtask

  task automatic pulse(input bit err, input bit fin);
    @(negedge clk);
    decodeErr = err; frameEnd = fin;
    @(negedge clk);
    decodeErr = 1'b0; frameEnd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkHeld(input logic [35:0] exp, input string tag);
    check({wrLock, wrData, wrAddr} == exp, tag, "held fields", {wrLock, wrData, wrAddr}, exp);
  endtask

  // monitor: scoreboard comparison of every pulse seen on the outputs
  always @(negedge clk) begin
    if (rstN) begin
      if (wrReq && rdReturn)
        check(1'b0, "R10", "wrReq and rdReturn together", 2'b11, 2'b00);
      else if (wrReq || rdReturn) begin
        if (expKind.size() == 0) begin
          check(1'b0, "R8", "unexpected pulse (wrReq,rdReturn)", {wrReq, rdReturn}, 2'b00);
        end else begin
          automatic bit k = expKind.pop_front();
          automatic logic [35:0] w = expWord.pop_front();
          automatic string t = expTag.pop_front();
          check(wrReq == k, t, "event kind (1=write)", wrReq, k);
          if (k && wrReq)
            check({wrLock, wrData, wrAddr} == w, t, "write fields", {wrLock, wrData, wrAddr}, w);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [38:0] f;
    idle(2);
    // R1: reset values
    check({wrReq, rdReturn, wrLock, wrData, wrAddr} == '0, "R1", "reset outputs",
          {wrReq, rdReturn, wrLock, wrData, wrAddr}, 0);
    rstN = 1'b1;
    idle(2);

    // R2: good frame, end strobe on its own cycle
    expectReq(1'b1, 32'hA5C3_0F96, 3'b100, "R2");
    sendBits(mkFrame(2'b10, 1'b1, 32'hA5C3_0F96, 3'b100), 38, 1'b0);
    pulse(1'b0, 1'b1);
    idle(3);

    // R9: last bit and end strobe together
    expectReq(1'b0, 32'h0000_0001, 3'b111, "R9");
    sendBits(mkFrame(2'b10, 1'b0, 32'h0000_0001, 3'b111), 38, 1'b1);
    idle(5);
    // R3: fields held after the pulse
    checkHeld({1'b0, 32'h0000_0001, 3'b111}, "R3");

    // R4: first opcode bit wrong; rest of frame discarded (R8)
    expectAbort("R4");
    sendBits(mkFrame(2'b00, 1'b1, 32'hFFFF_FFFF, 3'b010), 38, 1'b0);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    idle(3);
    checkHeld({1'b0, 32'h0000_0001, 3'b111}, "R8");

    // R4: second opcode bit wrong
    expectAbort("R4");
    sendBits(mkFrame(2'b11, 1'b0, 32'h1234_5678, 3'b001), 38, 1'b1);
    idle(3);

    // R5: 37 bits then end
    expectAbort("R5");
    f = mkFrame(2'b10, 1'b1, 32'hDEAD_BEEF, 3'b011);
    sendBits(f >> 1, 37, 1'b0);
    pulse(1'b0, 1'b1);
    idle(3);

    // R5: end strobe with no bits
    expectAbort("R5");
    pulse(1'b0, 1'b1);
    idle(3);

    // R6: 39 bits before end
    expectAbort("R6");
    sendBits({mkFrame(2'b10, 1'b1, 32'hCAFE_0001, 3'b101), 1'b1}, 39, 1'b0);
    pulse(1'b0, 1'b1);
    idle(3);

    // R7: error mid-frame, then ignored bits
    expectAbort("R7");
    sendBits(39'h2AA, 10, 1'b0);
    pulse(1'b1, 1'b0);
    sendBits(39'h15, 5, 1'b0);
    pulse(1'b0, 1'b1);
    idle(3);

    // R7: error and end together after a full good frame
    expectAbort("R7");
    sendBits(mkFrame(2'b10, 1'b1, 32'h7777_8888, 3'b110), 38, 1'b0);
    pulse(1'b1, 1'b1);
    idle(3);
    checkHeld({1'b0, 32'h0000_0001, 3'b111}, "R7");

    // R8: recovery with a fresh frame
    expectReq(1'b1, 32'hFFFF_FFFF, 3'b000, "R8");
    sendBits(mkFrame(2'b10, 1'b1, 32'hFFFF_FFFF, 3'b000), 38, 1'b0);
    pulse(1'b0, 1'b1);
    idle(5);
    checkHeld({1'b1, 32'hFFFF_FFFF, 3'b000}, "R3");
    check(expKind.size() == 0, "R2", "outstanding expected events", expKind.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule